// File: doc/BRIEF.md
# Sigma-Delta Decimation Channel

This block takes the one-bit output of a sigma-delta modulator and turns it into signed 24-bit conversion results. A third-order comb-integrator (sinc3) filter runs at the modulator rate and produces one output every R modulator samples, where R is the oversampling ratio. The 3-bit ratio select picks R from 64 to 2048. Each output is scaled so that full-scale input maps to a 24-bit code for every ratio. Outputs above the positive limit are clamped. The result is presented as a 32-bit word in one of two justifications.

The modulator clock enters as a level synchronous to the system clock. A rising or falling transition of that level, chosen by configuration, marks one modulator sample. After the channel is enabled, a start-up counter has to run out before the ready flag rises. Conversions then start on a trigger, which comes either from a one-cycle software pulse or from the rising edge of a hardware trigger line. In single mode, one result is made per trigger. In continuous mode, results keep coming after one trigger. A conversion-complete flag and a sticky overflow flag report result availability. Both flags are cleared by a read-acknowledge pulse.

Top module: `sdm_decim_channel`

## Requirements
- R1: Ratio select codes 0,1,2,3,4,5 give R = 64,128,256,512,1024,2048. Codes 6 and 7 behave as code 5.
- R2: For a periodic bitstream whose period divides R, with ones-density d, the published 24-bit value is (2d-1)·2^23. Example values: d=3/4 gives 0x400000, d=1/2 gives 0, and d=1/4 gives 0xC00000.
- R3: Values beyond the signed 24-bit range are saturated. An all-ones stream gives 0x7FFFFF. An all-zeros stream gives 0x800000 exactly.
- R4: With edge select 0, the modulator bit is sampled when the modulator clock rises. With edge select 1, it is sampled when the clock falls.
- R5: The channel is enabled only when master, filter and modulator enables are all 1. Ready is 0 from reset and while the channel is disabled. Ready becomes 1 on the (start-up count + 1)·16-th sample event after the channel is enabled.
- R6: With trigger select 0, only the software trigger pulse starts a conversion. With trigger select 1, only a rising edge of the hardware trigger does. A trigger has no effect unless the channel is ready and idle.
- R7: After a trigger, the first two decimated outputs are discarded. The first result is published, and conversion-complete set, on exactly the 3R-th sample event.
- R8: In single mode, after one result the channel returns to idle and publishes nothing more until the next trigger.
- R9: In continuous mode, a further result is published every R sample events after the first one.
- R10: A read-acknowledge pulse clears conversion-complete and overflow, unless a result is published in the same cycle.
- R11: Overflow is set when a result is published while conversion-complete is still 1. It stays set until it is cleared by a read or by disabling the channel.
- R12: With format 0, the output is {value[23:0], 8'h00}. With format 1, the output is the value sign-extended into bits 31:24. The format applies to the output combinationally.
- R13: Disabling the channel clears ready, conversion-complete and overflow, and stops any conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_clk | input | 1 | Modulator clock level, synchronous to clk |
| mod_bit | input | 1 | Modulator bitstream |
| master_en | input | 1 | Global enable shared by all channels |
| filt_en | input | 1 | Decimation filter enable |
| mod_en | input | 1 | Modulator enable |
| edge_fall | input | 1 | 0: sample on rising modulator clock, 1: on falling |
| osr_sel | input | 3 | Oversampling ratio code |
| cont_mode | input | 1 | 0: single conversion, 1: continuous |
| trig_hw_sel | input | 1 | 0: software trigger, 1: hardware trigger |
| sw_trig | input | 1 | Software trigger pulse |
| hw_trig | input | 1 | Hardware trigger line (rising edge) |
| fmt_right | input | 1 | 0: left-justified result, 1: right-justified |
| startup_cnt | input | 7 | Start-up length in units of 16 samples, minus one |
| rd_ack | input | 1 | Result read pulse |
| result | output | 32 | Formatted conversion result |
| ready | output | 1 | Start-up finished, channel can convert |
| conv_done | output | 1 | Conversion complete |
| overflow | output | 1 | Result overwritten before read |

## Verification
The filter is driven with constant and repeating bitstreams whose ones-density is 1, 3/4, 1/2, 1/4 and 0. For these streams the exact sinc3 output is known in closed form, so the scaling, the saturation at the positive limit and the exact negative full scale are each checked independently. The same 3/4-density stream is swept over every ratio code. At each ratio, the complete flag is checked one sample before and exactly at the 3R-th sample event, which separates the ratios by timing as well as by value. A stream that is high while the modulator clock is high and low while it is low gives opposite extremes for the two sampling edges. Short trigger, read and mode sequences check the ordering of ready, complete and overflow.

// File: rtl/sdm_decim_channel.sv
module sdm_decim_channel #(
  parameter int MIN_LOG2R = 6,
  parameter int MAX_LOG2R = 11,
  parameter int RES_W     = 24,
  parameter int SU_W      = 7,
  parameter int PRE_W     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mod_clk,
  input  logic            mod_bit,
  input  logic            master_en,
  input  logic            filt_en,
  input  logic            mod_en,
  input  logic            edge_fall,
  input  logic [2:0]      osr_sel,
  input  logic            cont_mode,
  input  logic            trig_hw_sel,
  input  logic            sw_trig,
  input  logic            hw_trig,
  input  logic            fmt_right,
  input  logic [SU_W-1:0] startup_cnt,
  input  logic            rd_ack,
  output logic [31:0]     result,
  output logic            ready,
  output logic            conv_done,
  output logic            overflow
);
  localparam int ACC_W  = 3*MAX_LOG2R + 3;
  localparam int WIDE_W = ACC_W + 8;
  localparam int NCODE  = MAX_LOG2R - MIN_LOG2R;
  localparam int PAD_W  = 32 - RES_W;
  localparam int CNT_W  = MAX_LOG2R;

  typedef enum logic {IDLE, RUN} st_t;

  st_t st;
  logic mclk_q, hw_q;
  logic en, se, trig, wrap, publish;
  logic [2:0] code;
  logic [CNT_W-1:0] dcnt, dlast;
  logic [PRE_W-1:0] pre;
  logic [SU_W-1:0] tick;
  logic [1:0] skip;
  logic signed [ACC_W-1:0] step, i1, i2, i3, d1, d2, d3, n1, n2, n3, k1, k2, k3;
  logic signed [WIDE_W-1:0] wide;
  logic signed [RES_W-1:0] res, sat;

  assign en    = master_en & filt_en & mod_en;
  assign se    = edge_fall ? (mclk_q & ~mod_clk) : (mod_clk & ~mclk_q);
  assign trig  = trig_hw_sel ? (hw_trig & ~hw_q) : sw_trig;
  assign code  = (osr_sel > 3'(NCODE)) ? 3'(NCODE) : osr_sel;
  assign dlast = CNT_W'((1 << (MIN_LOG2R + int'(code))) - 1);

  assign step = mod_bit ? ACC_W'(1) : '1;
  assign n1 = i1 + step;
  assign n2 = i2 + n1;
  assign n3 = i3 + n2;
  assign k1 = n3 - d1;
  assign k2 = k1 - d2;
  assign k3 = k2 - d3;

  assign wrap    = (st == RUN) && se && (dcnt == dlast);
  assign publish = wrap && (skip == 2'd0);

  always_comb begin
    wide = {{(WIDE_W-ACC_W){k3[ACC_W-1]}}, k3};
    if (3*(MIN_LOG2R + int'(code)) < RES_W-1)
      wide = wide <<< (RES_W-1 - 3*(MIN_LOG2R + int'(code)));
    else
      wide = wide >>> (3*(MIN_LOG2R + int'(code)) - (RES_W-1));
    if (!wide[WIDE_W-1] && |wide[WIDE_W-2:RES_W-1])
      sat = {1'b0, {(RES_W-1){1'b1}}};
    else if (wide[WIDE_W-1] && !(&wide[WIDE_W-2:RES_W-1]))
      sat = {1'b1, {(RES_W-1){1'b0}}};
    else
      sat = wide[RES_W-1:0];
  end

  assign result = fmt_right ? {{PAD_W{res[RES_W-1]}}, res} : {res, {PAD_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; mclk_q <= 1'b0; hw_q <= 1'b0;
      ready <= 1'b0; conv_done <= 1'b0; overflow <= 1'b0;
      pre <= '0; tick <= '0; dcnt <= '0; skip <= '0; res <= '0;
      i1 <= '0; i2 <= '0; i3 <= '0; d1 <= '0; d2 <= '0; d3 <= '0;
    end else begin
      mclk_q <= mod_clk;
      hw_q   <= hw_trig;
      if (!en) begin
        st <= IDLE; ready <= 1'b0; pre <= '0; tick <= '0;
        conv_done <= 1'b0; overflow <= 1'b0;
      end else begin
        if (se && !ready) begin
          pre <= pre + 1'b1;
          if (&pre) begin
            if (tick == startup_cnt) ready <= 1'b1;
            else tick <= tick + 1'b1;
          end
        end
        if (st == IDLE) begin
          if (ready && trig) begin
            st <= RUN; dcnt <= '0; skip <= 2'd2;
            i1 <= '0; i2 <= '0; i3 <= '0; d1 <= '0; d2 <= '0; d3 <= '0;
          end
        end else if (se) begin
          i1 <= n1; i2 <= n2; i3 <= n3;
          if (wrap) begin
            dcnt <= '0;
            d1 <= n3; d2 <= k1; d3 <= k2;
            if (skip != 2'd0) skip <= skip - 2'd1;
            else begin
              res <= sat;
              if (!cont_mode) st <= IDLE;
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        if (publish) begin
          conv_done <= 1'b1;
          if (rd_ack) overflow <= 1'b0;
          else if (conv_done) overflow <= 1'b1;
        end else if (rd_ack) begin
          conv_done <= 1'b0;
          overflow  <= 1'b0;
        end
      end
    end
  end

  a_r13_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ready && !conv_done && !overflow));
  a_r5_ready_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(se && en));
  a_r6_start_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == RUN) |-> $past(ready && trig));
  a_r7_done_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_done) |-> $past(se));
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !publish) |=> (!conv_done && !overflow));
  a_r11_ovr_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(conv_done));
endmodule

// File: tb/sim_sdm_decim_channel.sv
module sim_sdm_decim_channel;
  logic clk = 0, rst_n = 0;
  logic mod_clk = 0, mod_bit = 0, master_en = 0, filt_en = 0, mod_en = 0, edge_fall = 0;
  logic [2:0] osr_sel = 0;
  logic cont_mode = 0, trig_hw_sel = 0, sw_trig = 0, hw_trig = 0, fmt_right = 0, rd_ack = 0;
  logic [6:0] startup_cnt = 0;
  logic [31:0] result;
  logic ready, conv_done, overflow;
  int checks = 0, errors = 0, ph = 0;

  always #2 clk = ~clk;

  sdm_decim_channel u0 (.clk, .rst_n, .mod_clk, .mod_bit, .master_en, .filt_en, .mod_en,
    .edge_fall, .osr_sel, .cont_mode, .trig_hw_sel, .sw_trig, .hw_trig, .fmt_right,
    .startup_cnt, .rd_ack, .result, .ready, .conv_done, .overflow);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic edge_pair(input logic hi, input logic lo);
    @(negedge clk); mod_clk = 1; mod_bit = hi;
    @(negedge clk); mod_clk = 0; mod_bit = lo;
  endtask

  task automatic feed(input int n, input logic [3:0] pat);
    for (int i = 0; i < n; i++) begin
      edge_pair(pat[ph], pat[ph]);
      ph = (ph + 1) % 4;
    end
  endtask

  task automatic pulse_sw(); @(negedge clk); sw_trig = 1; @(negedge clk); sw_trig = 0; endtask
  task automatic pulse_hw(); @(negedge clk); hw_trig = 1; @(negedge clk); hw_trig = 0; endtask
  task automatic pulse_rd(); @(negedge clk); rd_ack = 1; @(negedge clk); rd_ack = 0; endtask

  task automatic convert(input int r, input logic [3:0] pat, input logic [31:0] exp, input string tag);
    pulse_sw();
    feed(3*r - 1, pat); settle();
    chk("R7 done early", {31'd0, conv_done}, 0);
    feed(1, pat); settle();
    chk("R7 done at 3R", {31'd0, conv_done}, 1);
    chk(tag, result, exp);
  endtask

  initial begin
    #(4*190000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset ready", {31'd0, ready}, 0);
    chk("R10 reset done/ovr", {30'd0, conv_done, overflow}, 0);
    chk("R12 reset result", result, 0);
    rst_n = 1;
    master_en = 1; mod_en = 1; startup_cnt = 7'd2;
    feed(40, 4'b1111); settle();
    chk("R5 ready needs filter enable", {31'd0, ready}, 0);
    filt_en = 1;
    feed(47, 4'b1111); settle();
    chk("R5 ready before start-up end", {31'd0, ready}, 0);
    feed(1, 4'b1111); settle();
    chk("R5 ready at start-up end", {31'd0, ready}, 1);

    for (int c = 0; c < 6; c++) begin
      osr_sel = 3'(c);
      convert(64 << c, 4'b0111, 32'h4000_0000, "R1 R2 ratio sweep 3/4 density");
      pulse_rd(); settle();
      chk("R10 read clears done", {31'd0, conv_done}, 0);
    end
    osr_sel = 0;
    convert(64, 4'b1111, 32'h7FFF_FF00, "R3 positive saturation");
    fmt_right = 1; settle(); chk("R12 right pos", result, 32'h007F_FFFF);
    fmt_right = 0; pulse_rd();
    convert(64, 4'b0000, 32'h8000_0000, "R3 negative full scale");
    fmt_right = 1; settle(); chk("R12 right neg", result, 32'hFF80_0000);
    fmt_right = 0; pulse_rd();
    convert(64, 4'b0101, 32'h0, "R2 half density");
    pulse_rd();
    convert(64, 4'b0001, 32'hC000_0000, "R2 quarter density");
    fmt_right = 1; settle(); chk("R12 right quarter", result, 32'hFFC0_0000);
    fmt_right = 0; pulse_rd();

    feed(5*64, 4'b0111); settle();
    chk("R8 single mode stays idle", {31'd0, conv_done}, 0);

    osr_sel = 3'd6;
    convert(2048, 4'b0111, 32'h4000_0000, "R1 code 6 as 2048");
    pulse_rd();
    osr_sel = 0;

    edge_fall = 1;
    pulse_sw();
    for (int i = 0; i < 192; i++) edge_pair(1, 0);
    settle();
    chk("R4 falling edge sample", result, 32'h8000_0000);
    pulse_rd();
    edge_fall = 0;
    pulse_sw();
    for (int i = 0; i < 192; i++) edge_pair(1, 0);
    settle();
    chk("R4 rising edge sample", result, 32'h7FFF_FF00);
    pulse_rd();

    pulse_hw(); feed(192, 4'b1111); settle();
    chk("R6 hw ignored when sw selected", {31'd0, conv_done}, 0);
    trig_hw_sel = 1;
    pulse_sw(); feed(192, 4'b1111); settle();
    chk("R6 sw ignored when hw selected", {31'd0, conv_done}, 0);
    pulse_hw(); feed(192, 4'b1111); settle();
    chk("R6 hw trigger starts", {31'd0, conv_done}, 1);
    pulse_rd();
    trig_hw_sel = 0;

    cont_mode = 1;
    convert(64, 4'b0001, 32'hC000_0000, "R9 continuous first");
    pulse_rd();
    feed(63, 4'b0001); settle();
    chk("R9 no result before R", {31'd0, conv_done}, 0);
    feed(1, 4'b0001); settle();
    chk("R9 result after R", {31'd0, conv_done}, 1);
    chk("R9 value", result, 32'hC000_0000);
    feed(64, 4'b0001); settle();
    chk("R11 overflow set", {30'd0, conv_done, overflow}, 2'b11);
    pulse_rd(); settle();
    chk("R10 read clears both", {30'd0, conv_done, overflow}, 0);
    feed(128, 4'b0001); settle();
    chk("R11 overflow again", {31'd0, overflow}, 1);
    master_en = 0; settle(); settle();
    chk("R13 disable clears", {29'd0, ready, conv_done, overflow}, 0);
    feed(128, 4'b0001); settle();
    chk("R13 stopped", {31'd0, conv_done}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule